// File: doc/BRIEF.md
# Rewindable FIFO Buffer with Occupancy Flags

A single-clock first-in first-out store for 9-bit words. Its depth is a power-of-two parameter from 256 to 4096 words. A producer writes by pulling an active-low write strobe down, and a consumer reads by pulling an active-low read strobe down. Words come out in the order they went in. Three flags report the fill level: empty, full, and more-than-half. These flags let both sides avoid underrun and overrun. The block drops any write it gets while full and any read it gets while empty.

All three control inputs (write strobe, read strobe and replay request) are resynchronised to the system clock through two flops and then edge-detected. One operation runs per high-to-low transition, however long the line then stays low. The write data is resynchronised alongside the write strobe, so the word captured is the one present when the strobe was first seen low. An active-low replay request, given while both strobes are idle, moves the read position back to the first location written after reset. The words already stored can then be read again. An active-low master reset empties the buffer.

Top module: `retx_fifo`

## Requirements
- R1: Words are returned in the order they were accepted. Each word is 9 bits wide and returned unchanged.
- R2: A write or read takes effect on the third rising clock edge after its strobe is first sampled low. Exactly one operation happens per high-to-low strobe transition, even if the strobe stays low for many cycles.
- R3: An accepted read loads `rd_data` with the oldest stored word. `rd_data` then holds that value until the next accepted read or reset.
- R4: `rd_oe` is 1 exactly when the read strobe, delayed by its two synchroniser flops, is low.
- R5: A write that arrives while `full` is 1 is dropped. The stored contents and the occupancy are unchanged.
- R6: A read that arrives while `empty` is 1 is dropped. `rd_data` and the read position are unchanged.
- R7: `empty` is 1 at occupancy 0. `full` is 1 at occupancy DEPTH. `half_full` is 1 when occupancy exceeds DEPTH/2.
- R8: A high-to-low transition on `rt_n`, seen while both synchronised strobes are high, sets the read position to address 0. It also sets the occupancy to the number of writes accepted since reset, capped at DEPTH, and the flags follow.
- R9: A replay request seen while either synchronised strobe is low is ignored, and reading continues from the current position.
- R10: While `mr_n` is 0 the buffer is emptied: `empty`=1, `full`=0, `half_full`=0, `rd_data`=0 and `rd_oe`=0.
- R11: A read and a write on the same edge both take effect. The exceptions are a read while empty, which is dropped while the write proceeds, and a write while full, which is dropped while the read proceeds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| mr_n | input | 1 | Master reset, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low |
| wr_data | input | 9 | Word to store |
| rd_n | input | 1 | Read strobe, active low |
| rt_n | input | 1 | Replay request, active low |
| rd_data | output | 9 | Last word read |
| rd_oe | output | 1 | Output enable, high while a read strobe is active |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals depth |
| half_full | output | 1 | Occupancy above half the depth |

## Verification
Each stimulus pattern separates one behaviour:
- Isolated writes followed by isolated reads show ordering and data integrity.
- A strobe held low for several cycles separates edge-triggered operation from level-triggered operation.
- Simultaneous read and write pulses, once on a non-empty buffer and once on an empty one, show which operation survives at each boundary.
- A complete fill with an extra write, followed by a full drain, tells a dropped overflow apart from a stored one.
- Replay requests are given twice: once with the strobes idle, where the read position must rewind, and once with the read strobe held low, where it must not.

// File: rtl/retx_fifo.sv
module retx_fifo #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             mr_n,
  input  logic             wr_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_n,
  input  logic             rt_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_oe,
  output logic             empty,
  output logic             full,
  output logic             half_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_HALF = CW'(DEPTH / 2);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [2:0]       wr_s, rd_s, rt_s;
  logic [WIDTH-1:0] d0, d1;
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic             wrapped;

  wire wr_fall = wr_s[2] & ~wr_s[1];
  wire rd_fall = rd_s[2] & ~rd_s[1];
  wire rt_go   = rt_s[2] & ~rt_s[1] & wr_s[1] & rd_s[1];
  wire do_wr   = wr_fall & ~full;
  wire do_rd   = rd_fall & ~empty;

  assign empty     = (count == '0);
  assign full      = (count == CNT_FULL);
  assign half_full = (count > CNT_HALF);
  assign rd_oe     = ~rd_s[1];

  always_ff @(posedge clk or negedge mr_n) begin
    if (!mr_n) begin
      wr_s <= '1;
      rd_s <= '1;
      rt_s <= '1;
      d0   <= '0;
      d1   <= '0;
    end else begin
      wr_s <= {wr_s[1:0], wr_n};
      rd_s <= {rd_s[1:0], rd_n};
      rt_s <= {rt_s[1:0], rt_n};
      d0   <= wr_data;
      d1   <= d0;
    end
  end

  always_ff @(posedge clk or negedge mr_n) begin
    if (!mr_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      wrapped <= 1'b0;
      rd_data <= '0;
    end else if (rt_go) begin
      rptr  <= '0;
      count <= wrapped ? CNT_FULL : {1'b0, wptr};
    end else begin
      if (do_wr) begin
        wptr <= wptr + 1'b1;
        if (wptr == PTR_LAST) wrapped <= 1'b1;
      end
      if (do_rd) begin
        rd_data <= mem[rptr];
        rptr    <= rptr + 1'b1;
      end
      count <= count + CW'(do_wr) - CW'(do_rd);
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= d1;
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!mr_n)
    (full && wr_fall && !rd_fall) |=> ($stable(wptr) && full));

  // R6
  no_underrun_chk: assert property (@(posedge clk) disable iff (!mr_n)
    (empty && rd_fall) |=> ($stable(rd_data) && $stable(rptr)));

  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!mr_n)
    $onehot0({empty, half_full}) && !(empty && full));

  // R8
  rewind_chk: assert property (@(posedge clk) disable iff (!mr_n)
    rt_go |=> (rptr == '0));

  // R2
  one_step_chk: assert property (@(posedge clk) disable iff (!mr_n)
    !rt_go |=> (count == $past(count) || count == $past(count) + 1'b1 ||
                count == $past(count) - 1'b1));

  // R9
  rt_blocked_chk: assert property (@(posedge clk) disable iff (!mr_n)
    (!rd_s[1] && !rd_fall && !wr_fall) |=> $stable(rptr));
endmodule

// File: tb/sim_retx_fifo.sv
module sim_retx_fifo;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       mr_n = 1'b0, wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic       rd_oe, empty, full, half_full;

  retx_fifo #(.DEPTH(DEPTH), .WIDTH(9)) u0 (
    .clk(clk), .mr_n(mr_n), .wr_n(wr_n), .wr_data(wr_data), .rd_n(rd_n),
    .rt_n(rt_n), .rd_data(rd_data), .rd_oe(rd_oe), .empty(empty),
    .full(full), .half_full(half_full));

  int    vectors = 0, misses = 0;
  bit    done = 0;
  string phase = "reset";

  logic [8:0] q[$], written[$];
  logic [8:0] exp_data = '0;
  bit wh1 = 1, wh2 = 1, wh3 = 1, rh1 = 1, rh2 = 1, rh3 = 1, th1 = 1, th2 = 1, th3 = 1;
  logic [8:0] dh1 = '0, dh2 = '0;
  bit wop, rop, rtop, rok, wok;
  int sz;

  task automatic cmp(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s [%s] actual %0h expected %0h at %0t", req, phase, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!mr_n) begin
      q.delete(); written.delete(); exp_data = '0;
      wh1 = 1; wh2 = 1; wh3 = 1; rh1 = 1; rh2 = 1; rh3 = 1; th1 = 1; th2 = 1; th3 = 1;
      dh1 = '0; dh2 = '0;
    end else begin
      wop  = (wh2 == 0) && (wh3 == 1);
      rop  = (rh2 == 0) && (rh3 == 1);
      rtop = (th2 == 0) && (th3 == 1) && wh2 && rh2;
      sz   = q.size();
      if (rtop) q = written;
      else begin
        rok = rop && (sz > 0);
        wok = wop && (sz < DEPTH);
        if (rok) exp_data = q.pop_front();
        if (wok) begin q.push_back(dh2); written.push_back(dh2); end
      end
      wh3 = wh2; wh2 = wh1; wh1 = wr_n;
      rh3 = rh2; rh2 = rh1; rh1 = rd_n;
      th3 = th2; th2 = th1; th1 = rt_n;
      dh2 = dh1; dh1 = wr_data;
    end
    #2;
    if (mr_n && !done) begin
      cmp("R3", rd_data, exp_data);
      cmp("R4", rd_oe, int'(!rh2));
      cmp("R7 empty", empty, int'(q.size() == 0));
      cmp("R7 full", full, int'(q.size() == DEPTH));
      cmp("R7 half", half_full, int'(q.size() > DEPTH / 2));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(input logic [8:0] d);
    @(negedge clk) begin wr_n = 0; wr_data = d; end
    @(negedge clk) wr_n = 1;
  endtask
  task automatic rd();
    @(negedge clk) rd_n = 0;
    @(negedge clk) rd_n = 1;
  endtask
  task automatic both(input logic [8:0] d);
    @(negedge clk) begin wr_n = 0; rd_n = 0; wr_data = d; end
    @(negedge clk) begin wr_n = 1; rd_n = 1; end
  endtask
  task automatic rt();
    @(negedge clk) rt_n = 0;
    @(negedge clk) rt_n = 1;
  endtask
  task automatic do_reset();
    @(negedge clk) mr_n = 0;
    idle(2);
    mr_n = 1;
    idle(2);
  endtask

  initial begin
    idle(3);
    mr_n = 1;
    idle(2);
    phase = "R10 reset state";
    cmp("R10", empty, 1); cmp("R10", full, 0); cmp("R10", half_full, 0);
    cmp("R10", rd_data, 0); cmp("R10", rd_oe, 0);

    phase = "R1 order";
    for (int i = 0; i < 5; i++) wr(9'(i * 29 + 3));
    idle(4);
    for (int i = 0; i < 5; i++) begin
      rd(); idle(3);
      cmp("R1", rd_data, i * 29 + 3);
    end

    phase = "R6 empty read";
    rd(); rd(); idle(4);
    cmp("R6", rd_data, 4 * 29 + 3); cmp("R6", empty, 1);

    phase = "R2 held strobe";
    @(negedge clk) begin wr_n = 0; wr_data = 9'h155; end
    idle(6);
    wr_n = 1;
    idle(4);
    cmp("R2", empty, 0);
    rd(); idle(4);
    cmp("R2", rd_data, 9'h155); cmp("R2", empty, 1);

    phase = "R11 simultaneous";
    wr(9'h0AA); idle(4);
    both(9'h133); idle(4);
    cmp("R11", rd_data, 9'h0AA); cmp("R11", empty, 0);
    rd(); idle(4);
    cmp("R11", rd_data, 9'h133); cmp("R11", empty, 1);
    both(9'h1C7); idle(4);
    cmp("R11", rd_data, 9'h133); cmp("R11", empty, 0);
    rd(); idle(4);
    cmp("R11", rd_data, 9'h1C7);

    phase = "R10 reset with data";
    wr(9'h011); wr(9'h022); idle(4);
    do_reset();
    cmp("R10", empty, 1); cmp("R10", rd_data, 0);

    phase = "R5 R7 fill";
    for (int i = 0; i < DEPTH; i++) begin
      wr(9'(i) ^ 9'h0A5);
      if (i == DEPTH / 2 - 1) begin idle(4); cmp("R7", half_full, 0); end
      if (i == DEPTH / 2)     begin idle(4); cmp("R7", half_full, 1); end
    end
    idle(4);
    cmp("R7", full, 1);
    wr(9'h1FF); idle(4);
    cmp("R5", full, 1);
    for (int i = 0; i < 10; i++) rd();
    idle(4);
    cmp("R1", rd_data, 9 ^ 9'h0A5);

    phase = "R8 replay full";
    rt(); idle(4);
    cmp("R8", full, 1);
    rd(); idle(4);
    cmp("R8", rd_data, 9'h0A5);
    for (int i = 1; i < DEPTH; i++) rd();
    idle(4);
    cmp("R5", empty, 1);
    cmp("R5", rd_data, (DEPTH - 1) ^ 9'h0A5);

    phase = "R8 replay partial";
    do_reset();
    wr(9'h101); wr(9'h102); wr(9'h103); idle(4);
    rd(); rd(); idle(4);
    rt(); idle(4);
    cmp("R8", half_full, 0); cmp("R8", empty, 0);
    rd(); idle(4);
    cmp("R8", rd_data, 9'h101);

    phase = "R9 blocked replay";
    do_reset();
    wr(9'h0E1); wr(9'h0E2); wr(9'h0E3); idle(4);
    rd(); idle(4);
    @(negedge clk) rd_n = 0;
    idle(3);
    cmp("R4", rd_oe, 1);
    rt_n = 0; idle(2); rt_n = 1; idle(3);
    rd_n = 1; idle(4);
    rd(); idle(4);
    cmp("R9", rd_data, 9'h0E3); cmp("R9", empty, 1);

    idle(2);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule